// File: doc/BRIEF.md
# Trigger Gating and Delay Unit

This block turns a set of per-cycle trigger strobes into a timed gate window. A mask picks any subset of the trigger inputs, and the selected strobes are merged by OR. A merged strobe starts a small state machine that counts clock cycles from the trigger edge. The gate becomes active once the count reaches the programmed start delay. It turns inactive once the count reaches the programmed stop delay, which is also measured from the trigger edge. The block also gives a one-cycle strobe at the moment the gate becomes active. An optional inversion flips the gate level before it leaves the block.

Several instances are meant to sit side by side. Triggers that enter one instance can only be ORed. An AND of two triggers is built downstream: each trigger drives its own instance, and the gate outputs are combined. All pins are plain control and status levels, sampled on every rising clock edge, so the block has no handshake and no back-pressure. The configuration inputs are expected to stay stable while a window is in progress.

Top module: `gate_delay_unit`

## Requirements
- R1: After reset, and whenever no window is in progress, `gate_o` equals `cfg_invert` and `gate_open_o` is 0.
- R2: A trigger input whose bit in `cfg_mask` is 0 never starts or restarts a window.
- R3: Any cycle in which at least one selected input (`trig_i & cfg_mask` nonzero) is 1 counts as a single trigger, however many of those inputs are high.
- R4: A trigger accepted at rising edge t makes the non-inverted gate active from edge t+`cfg_start`. With `cfg_start` = 0, this is edge t itself.
- R5: The gate returns inactive at edge t+`cfg_stop`, so it stays active for exactly `cfg_stop`-`cfg_start` cycles.
- R6: If `cfg_stop` <= `cfg_start`, an accepted trigger never makes the gate active and never produces an open strobe.
- R7: With `cfg_retrig` = 0, a trigger that arrives at edges t+1 through t+`cfg_stop` (inclusive) of a window started at edge t is ignored.
- R8: With `cfg_retrig` = 1, a trigger during a window restarts both delays from the new trigger edge.
- R9: `gate_o` is the non-inverted gate level XOR `cfg_invert`. The inversion has no effect on `gate_open_o`.
- R10: `gate_open_o` is high for exactly the one cycle in which the non-inverted gate goes from inactive to active. This includes a re-opening after a retrigger. A retrigger that keeps the gate active (`cfg_start` = 0) gives no second strobe.
- R11: A trigger at edge t+`cfg_stop`+1, one cycle after the window closes, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | N_TRIG | Per-cycle trigger strobes |
| cfg_mask | input | N_TRIG | Selects which trigger inputs take part (1 = used) |
| cfg_start | input | DLY_W | Cycles from trigger edge to gate active |
| cfg_stop | input | DLY_W | Cycles from trigger edge to gate inactive |
| cfg_retrig | input | 1 | 1 = triggers during a window restart it |
| cfg_invert | input | 1 | 1 = gate output is inverted |
| gate_o | output | 1 | Gate level, after the optional inversion |
| gate_open_o | output | 1 | One-cycle strobe when the gate becomes active |

## Verification
The hardest case to reach is a trigger that lands exactly on the closing edge t+`cfg_stop`. On that edge the state machine leaves the open state and may be about to accept triggers again. The next hard case is the cycle right after it, where the block must accept a trigger again. The stimulus places strobes at those exact cycle offsets from a known first trigger. A second hard case is a retrigger in the middle of an open window, which must first close the gate and then reopen it. A third is a retrigger with `cfg_start` = 0, which must keep the gate active with no new strobe. Every scenario is run with a mask that leaves some inputs out, and unselected inputs are toggled throughout.

// File: rtl/gate_pkg.sv
package gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_OPEN  = 2'd2,
    ST_DONE  = 2'd3
  } gate_state_e;
endpackage

// File: rtl/gate_trig_select.sv
module gate_trig_select #(
  parameter int N_TRIG = 8
) (
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [N_TRIG-1:0] mask_i,
  output logic              hit_o
);
  logic [N_TRIG-1:0] picked;

  // per-input qualification
  for (genvar g = 0; g < N_TRIG; g++) begin : g_pick
    assign picked[g] = trig_i[g] & mask_i[g];
  end

  assign hit_o = |picked;
endmodule

// File: rtl/gate_delay_cnt.sv
module gate_delay_cnt #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [DLY_W-1:0] start_i,
  input  logic [DLY_W-1:0] stop_i,
  output logic             at_start_o,
  output logic             at_stop_o
);
  localparam logic [DLY_W-1:0] CNT_MAX = {DLY_W{1'b1}};

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_nx;

  // elapsed edges after the one that will be taken next, saturating
  assign cnt_nx     = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign at_start_o = (cnt_nx >= start_i);
  assign at_stop_o  = (cnt_nx >= stop_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm #(
  parameter int DLY_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hit_i,
  input  logic                  retrig_i,
  input  logic [DLY_W-1:0]      start_i,
  input  logic [DLY_W-1:0]      stop_i,
  input  logic                  at_start_i,
  input  logic                  at_stop_i,
  output logic                  clear_o,
  output logic                  step_o,
  output logic                  enter_open_o,
  output gate_pkg::gate_state_e state_o
);
  import gate_pkg::*;

  gate_state_e state_q, state_d;
  logic        take;
  logic        empty_win;
  gate_state_e launch_st;

  assign empty_win = (stop_i <= start_i);
  assign launch_st = empty_win ? ST_DONE :
                     (start_i == '0) ? ST_OPEN : ST_WAIT;

  always_comb begin
    take    = 1'b0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (hit_i) begin
          take    = 1'b1;
          state_d = launch_st;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (hit_i && retrig_i) begin
          take    = 1'b1;
          state_d = launch_st;
        end else if (at_stop_i) begin
          state_d = ST_DONE;
        end else if (at_start_i) begin
          state_d = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (hit_i && retrig_i) begin
          take    = 1'b1;
          state_d = launch_st;
        end else if (at_stop_i) begin
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign clear_o      = take;
  assign step_o       = (state_q == ST_WAIT) || (state_q == ST_OPEN);
  assign enter_open_o = (state_d == ST_OPEN) && (state_q != ST_OPEN);
  assign state_o      = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/gate_out_stage.sv
module gate_out_stage (
  input  logic                  clk,
  input  logic                  rst_n,
  input  gate_pkg::gate_state_e state_i,
  input  logic                  enter_open_i,
  input  logic                  invert_i,
  output logic                  gate_o,
  output logic                  open_pulse_o
);
  import gate_pkg::*;

  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= enter_open_i;
  end

  assign gate_o       = (state_i == ST_OPEN) ^ invert_i;
  assign open_pulse_o = pulse_q;
endmodule

// File: rtl/gate_delay_unit.sv
module gate_delay_unit #(
  parameter int N_TRIG = 8,
  parameter int DLY_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [N_TRIG-1:0] cfg_mask,
  input  logic [DLY_W-1:0]  cfg_start,
  input  logic [DLY_W-1:0]  cfg_stop,
  input  logic              cfg_retrig,
  input  logic              cfg_invert,
  output logic              gate_o,
  output logic              gate_open_o
);
  import gate_pkg::*;

  logic        hit;
  logic        at_start, at_stop;
  logic        cnt_clear, cnt_step;
  logic        enter_open;
  gate_state_e state_q;

  gate_trig_select #(.N_TRIG(N_TRIG)) u_sel (
    .trig_i (trig_i),
    .mask_i (cfg_mask),
    .hit_o  (hit)
  );

  gate_delay_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (cnt_clear),
    .step_i     (cnt_step),
    .start_i    (cfg_start),
    .stop_i     (cfg_stop),
    .at_start_o (at_start),
    .at_stop_o  (at_stop)
  );

  gate_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (hit),
    .retrig_i     (cfg_retrig),
    .start_i      (cfg_start),
    .stop_i       (cfg_stop),
    .at_start_i   (at_start),
    .at_stop_i    (at_stop),
    .clear_o      (cnt_clear),
    .step_o       (cnt_step),
    .enter_open_o (enter_open),
    .state_o      (state_q)
  );

  gate_out_stage u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (state_q),
    .enter_open_i (enter_open),
    .invert_i     (cfg_invert),
    .gate_o       (gate_o),
    .open_pulse_o (gate_open_o)
  );
endmodule

// File: rtl/gate_delay_unit_chk.sv
module gate_delay_unit_chk #(
  parameter int N_TRIG = 8,
  parameter int DLY_W  = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_TRIG-1:0]     trig_i,
  input logic [N_TRIG-1:0]     cfg_mask,
  input logic [DLY_W-1:0]      cfg_start,
  input logic [DLY_W-1:0]      cfg_stop,
  input logic                  cfg_retrig,
  input logic                  cfg_invert,
  input logic                  gate_o,
  input logic                  gate_open_o,
  input gate_pkg::gate_state_e fsm_state
);
  import gate_pkg::*;

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_open_o |=> !gate_open_o);

  // R10
  pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_open_o |-> (gate_o != cfg_invert));

  // R6
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_stop <= cfg_start) |-> !gate_open_o);

  // R7
  hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_OPEN && !cfg_retrig) |=> (fsm_state == ST_OPEN || fsm_state == ST_DONE));

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_IDLE) |-> (gate_o == cfg_invert));

  // R2
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_IDLE && (trig_i & cfg_mask) == '0) |=> (fsm_state == ST_IDLE));
endmodule

bind gate_delay_unit gate_delay_unit_chk #(.N_TRIG(N_TRIG), .DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_i      (trig_i),
  .cfg_mask    (cfg_mask),
  .cfg_start   (cfg_start),
  .cfg_stop    (cfg_stop),
  .cfg_retrig  (cfg_retrig),
  .cfg_invert  (cfg_invert),
  .gate_o      (gate_o),
  .gate_open_o (gate_open_o),
  .fsm_state   (state_q)
);

// File: tb/tb_gate_delay_unit.sv
module tb_gate_delay_unit;
  localparam int N_TRIG = 8;
  localparam int DLY_W  = 12;
  localparam int MAXL   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_TRIG-1:0] trig_i = '0;
  logic [N_TRIG-1:0] cfg_mask = '0;
  logic [DLY_W-1:0]  cfg_start = '0;
  logic [DLY_W-1:0]  cfg_stop = '0;
  logic              cfg_retrig = 1'b0;
  logic              cfg_invert = 1'b0;
  logic              gate_o;
  logic              gate_open_o;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  logic [N_TRIG-1:0] sched [MAXL];
  logic [1:0]        exp_q [$];
  string             tag_q [$];

  always #10 clk = ~clk;

  gate_delay_unit #(.N_TRIG(N_TRIG), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cfg_mask(cfg_mask),
    .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_retrig(cfg_retrig),
    .cfg_invert(cfg_invert), .gate_o(gate_o), .gate_open_o(gate_open_o)
  );

  // monitor: compares one expected item per cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (gate_o !== e[1] || gate_open_o !== e[0]) begin
        fails++;
        $display("FAIL %s: gate/open actual %b%b expected %b%b at %0t",
                 t, gate_o, gate_open_o, e[1], e[0], $time);
      end
    end
  end

  task automatic clear_sched();
    for (int i = 0; i < MAXL; i++) sched[i] = '0;
  endtask

  // driver: build expectations from the requirements, then drive
  task automatic run_case(input string tag, input logic [N_TRIG-1:0] m,
                          input int s, input int p, input bit rt,
                          input bit inv, input int len);
    bit exp_g [MAXL];
    bit prev;
    int busy_end;
    busy_end = -1;
    for (int k = 0; k < MAXL; k++) exp_g[k] = 1'b0;
    for (int k = 0; k < len; k++) begin
      if ((sched[k] & m) != '0) begin          // R2 R3
        if (rt || k > busy_end) begin          // R7 R8 R11
          for (int j = k; j < MAXL; j++) exp_g[j] = 1'b0;
          if (p > s) begin                     // R4 R5 R6
            for (int j = k + s; j < k + p && j < MAXL; j++) exp_g[j] = 1'b1;
            busy_end = k + p;
          end else begin
            busy_end = k;
          end
        end
      end
    end
    @(negedge clk);
    cfg_mask = m; cfg_start = DLY_W'(s); cfg_stop = DLY_W'(p);
    cfg_retrig = rt; cfg_invert = inv;
    prev = 1'b0;
    for (int k = 0; k < len; k++) begin
      trig_i = sched[k];
      @(posedge clk);
      exp_q.push_back({exp_g[k] ^ inv, exp_g[k] & !prev});  // R9 R10
      tag_q.push_back(tag);
      prev = exp_g[k];
      @(negedge clk);
    end
    trig_i = '0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    if (gate_o !== 1'b0 || gate_open_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset gate/open actual %b%b expected 00", gate_o, gate_open_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 with R2: unselected bit 6 toggles, selected bit 1 fires
    clear_sched();
    sched[2] = 8'h02; sched[15] = 8'h40; sched[18] = 8'hC0;
    run_case("R4 R5 R2", 8'h0F, 3, 7, 1'b0, 1'b0, 25);

    // R3: two selected bits in one cycle, start at zero
    clear_sched();
    sched[1] = 8'h06; sched[10] = 8'h84;
    run_case("R3 R4", 8'h06, 0, 4, 1'b0, 1'b0, 18);

    // R6: empty windows
    clear_sched();
    sched[1] = 8'h01;
    run_case("R6 equal", 8'h01, 5, 5, 1'b0, 1'b0, 12);
    clear_sched();
    sched[3] = 8'h01;
    run_case("R6 below", 8'h01, 6, 2, 1'b1, 1'b0, 12);

    // R7 and R11: ignored at t+3 and t+stop, accepted one cycle later
    clear_sched();
    sched[1] = 8'h10; sched[4] = 8'h10; sched[7] = 8'h10; sched[8] = 8'h10;
    run_case("R7 R11", 8'h10, 2, 6, 1'b0, 1'b0, 22);

    // R7 during wait phase
    clear_sched();
    sched[1] = 8'h08; sched[3] = 8'h08;
    run_case("R7 wait", 8'h08, 4, 7, 1'b0, 1'b0, 16);

    // R8 R10: retrigger while open closes then reopens
    clear_sched();
    sched[1] = 8'h20; sched[5] = 8'h20;
    run_case("R8 R10 reopen", 8'h20, 2, 6, 1'b1, 1'b0, 20);

    // R8 R10: retrigger with zero start keeps gate open, no second strobe
    clear_sched();
    sched[1] = 8'h01; sched[3] = 8'h01;
    run_case("R8 R10 extend", 8'h01, 0, 4, 1'b1, 1'b0, 14);

    // R9: inverted output, pulse unchanged
    clear_sched();
    sched[2] = 8'h80;
    run_case("R9 invert", 8'h80, 1, 3, 1'b0, 1'b1, 10);

    // R2: all inputs pulsed but mask empty
    clear_sched();
    for (int i = 0; i < 6; i++) sched[i] = 8'hFF;
    run_case("R2 empty mask", 8'h00, 0, 3, 1'b1, 1'b0, 10);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule